// File: doc/BRIEF.md
# Raster Video Controller Register and Interrupt Unit

This block holds the processor-visible registers of a raster video controller and its interrupt logic. The processor reaches it through an address, a write strobe and a write byte. The read byte is combinational from the address. On a read, the block substitutes live values for some stored bytes: the current raster line, a light-pen position held elsewhere, and the interrupt state. The remaining locations behave as plain storage, and some of them have fixed high bits.

There are four interrupt sources. Each one reaches the block as a one-cycle pulse and sets a pending flag. A mask selects which pending flags may raise the interrupt line. A summary bit, kept in bit 7 of the pending register, records whether the line is asserted. The summary is evaluated again on every flag event, every flag-clear write and every mask write. The active-high `irq` output follows the summary bit.

Top module: `vidreg_irq_unit`

## Requirements
- R1: Only address bits 5:0 select a register, so any two addresses that agree in those six bits reach the same register for both reads and writes.
- R2: A read of location 0x11 returns bits 6:0 of the byte last written there, with bit 7 equal to bit 8 of `raster_line`.
- R3: A read of 0x12 returns `raster_line[7:0]`. A read of 0x13 returns `pen_x` and a read of 0x14 returns `pen_y`. Writes to these locations do not change what they read back.
- R4: A read of the pending register (0x19) returns the summary in bit 7, ones in bits 6:4 and the flags in bits 3:0. A read of the mask register (0x1A) returns ones in bits 7:4 and the mask in bits 3:0.
- R5: Any other location below 0x20 returns the byte last written there. Locations 0x20 to 0x2E return that byte with bits 7:4 forced to one. Locations 0x2F to 0x3F always return 0xFF.
- R6: A write to 0x19 clears each flag in bits 3:0 whose data bit is one and leaves the other flags unchanged. Data bit 7 has no effect. A source pulse in the same cycle as a clear write keeps its flag set.
- R7: A write to 0x1A stores data bits 3:0 as the mask and discards bits 7:4.
- R8: A pulse on `src_pulse[i]` sets flag i. Bit 0 is raster compare, bit 1 is sprite-to-background collision, bit 2 is sprite-to-sprite collision and bit 3 is an accepted light-pen trigger.
- R9: After the edge that applies a flag or mask update, `irq` and the summary bit are both one if (flags AND mask) is nonzero, and both zero otherwise.
- R10: Reset clears every stored byte, all flags, the mask, the summary and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W | Register address; only bits 5:0 are decoded |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte for `cpu_addr` |
| raster_line | input | RASTER_W | Current raster line |
| pen_x | input | 8 | Latched light-pen horizontal position |
| pen_y | input | 8 | Latched light-pen vertical position |
| src_pulse | input | 4 | One-cycle interrupt source events |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that each source pulse lasts one clock and that the write strobe is sampled only on rising edges. They also assume that `raster_line`, `pen_x` and `pen_y` are treated as live inputs that need no registering. The directed stimulus changes every input on the falling edge and raises each pulse and write for exactly one cycle, so the flag and mask properties see a single clean update per edge. Reads are checked one time unit after the falling edge, once the combinational read path has settled on the state left by the previous rising edge.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
   localparam int REG_AW   = 6;
   localparam int DATA_W   = 8;
   localparam int NSRC     = 4;
   localparam logic [REG_AW-1:0] A_CTRL1  = 6'h11;
   localparam logic [REG_AW-1:0] A_RASTER = 6'h12;
   localparam logic [REG_AW-1:0] A_PENX   = 6'h13;
   localparam logic [REG_AW-1:0] A_PENY   = 6'h14;
   localparam logic [REG_AW-1:0] A_PEND   = 6'h19;
   localparam logic [REG_AW-1:0] A_MASK   = 6'h1A;
   localparam logic [REG_AW-1:0] A_NIBHI  = 6'h20;
   localparam logic [REG_AW-1:0] A_ALLONE = 6'h2F;
   localparam int STORE_DEPTH = 47;
   localparam int SRC_RASTER = 0;
   localparam int SRC_SPRBG  = 1;
   localparam int SRC_SPRSPR = 2;
   localparam int SRC_PEN    = 3;
endpackage

// File: rtl/vidreg_store.sv
module vidreg_store
   import vidreg_pkg::*;
#(
   parameter int DEPTH = STORE_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [REG_AW-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_byte
);
   localparam int IDX_LIM = 1 << REG_AW;

   if (DEPTH < 1 || DEPTH > IDX_LIM) begin : g_bad_depth
      $error("vidreg_store: DEPTH out of range");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[gi] <= '0;
         end else if (we && (int'(wr_idx) == gi)) begin
            mem_q[gi] <= wdata;
         end
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (int'(rd_idx) == k) rd_byte = mem_q[k];
      end
   end

   // R10: storage is zero right after reset is released
   p_store_reset_r10: assert property (@(posedge clk)
      $rose(rst_n) |-> (mem_q[0] == '0));
endmodule

// File: rtl/vidreg_irq.sv
module vidreg_irq
   import vidreg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_pulse,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_bits,
   input  logic            mask_we,
   input  logic [NSRC-1:0] mask_in,
   output logic [NSRC-1:0] flags_q,
   output logic [NSRC-1:0] mask_q,
   output logic            summary_q
);
   logic [NSRC-1:0] flags_d, mask_d, clr_eff;
   logic            summary_d, upd;

   always_comb begin
      clr_eff   = clr_we ? clr_bits : '0;
      flags_d   = (flags_q & ~clr_eff) | src_pulse;
      mask_d    = mask_we ? mask_in : mask_q;
      upd       = clr_we | mask_we | (|src_pulse);
      summary_d = upd ? (|(flags_d & mask_d)) : summary_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q   <= '0;
         mask_q    <= '0;
         summary_q <= 1'b0;
      end else begin
         flags_q   <= flags_d;
         mask_q    <= mask_d;
         summary_q <= summary_d;
      end
   end

   // R9: summary agrees with the masked flags after every update
   p_summary_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      summary_q == (|(flags_q & mask_q)));
   // R8: a source pulse leaves its flag set
   p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      src_pulse[SRC_PEN] |=> flags_q[SRC_PEN]);
   // R6: a clear write without a competing pulse clears bit 0
   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[SRC_RASTER] && !src_pulse[SRC_RASTER]) |=> !flags_q[SRC_RASTER]);
   // R6: flags hold without pulses or clear writes
   p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && (src_pulse == '0)) |=> $stable(flags_q));
   // R7: mask changes only on a mask write
   p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/vidreg_rdmux.sv
module vidreg_rdmux
   import vidreg_pkg::*;
#(
   parameter int RASTER_W = 9
) (
   input  logic [REG_AW-1:0]   idx,
   input  logic [DATA_W-1:0]   stored,
   input  logic [RASTER_W-1:0] raster_line,
   input  logic [DATA_W-1:0]   pen_x,
   input  logic [DATA_W-1:0]   pen_y,
   input  logic [NSRC-1:0]     flags,
   input  logic [NSRC-1:0]     mask,
   input  logic                summary,
   output logic [DATA_W-1:0]   rdata
);
   if (RASTER_W < 9) begin : g_bad_raster
      $error("vidreg_rdmux: RASTER_W must be at least 9");
   end

   always_comb begin
      unique case (idx)
         A_CTRL1:  rdata = {raster_line[8], stored[6:0]};
         A_RASTER: rdata = raster_line[7:0];
         A_PENX:   rdata = pen_x;
         A_PENY:   rdata = pen_y;
         A_PEND:   rdata = {summary, 3'b111, flags};
         A_MASK:   rdata = {4'hF, mask};
         default: begin
            if (idx < A_NIBHI)        rdata = stored;
            else if (idx < A_ALLONE)  rdata = {4'hF, stored[3:0]};
            else                      rdata = 8'hFF;
         end
      endcase
   end
endmodule

// File: rtl/vidreg_irq_unit.sv
module vidreg_irq_unit
   import vidreg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int RASTER_W = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic                cpu_we,
   input  logic [7:0]          cpu_wdata,
   output logic [7:0]          cpu_rdata,
   input  logic [RASTER_W-1:0] raster_line,
   input  logic [7:0]          pen_x,
   input  logic [7:0]          pen_y,
   input  logic [3:0]          src_pulse,
   output logic                irq
);
   if (ADDR_W < REG_AW) begin : g_bad_addr
      $error("vidreg_irq_unit: ADDR_W must be at least 6");
   end

   logic [REG_AW-1:0] idx;
   logic [DATA_W-1:0] stored;
   logic [NSRC-1:0]   flags, mask;
   logic              summary, st_we, clr_we, mask_we;

   assign idx     = cpu_addr[REG_AW-1:0];
   assign st_we   = cpu_we && (idx < A_ALLONE);
   assign clr_we  = cpu_we && (idx == A_PEND);
   assign mask_we = cpu_we && (idx == A_MASK);

   vidreg_store #(.DEPTH(STORE_DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .we(st_we), .wr_idx(idx), .wdata(cpu_wdata),
      .rd_idx(idx), .rd_byte(stored)
   );

   vidreg_irq u_irq (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
      .clr_we(clr_we), .clr_bits(cpu_wdata[NSRC-1:0]),
      .mask_we(mask_we), .mask_in(cpu_wdata[NSRC-1:0]),
      .flags_q(flags), .mask_q(mask), .summary_q(summary)
   );

   vidreg_rdmux #(.RASTER_W(RASTER_W)) u_rdmux (
      .idx(idx), .stored(stored), .raster_line(raster_line),
      .pen_x(pen_x), .pen_y(pen_y), .flags(flags), .mask(mask),
      .summary(summary), .rdata(cpu_rdata)
   );

   assign irq = summary;

   // R5: top locations read all ones
   p_top_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx >= A_ALLONE) |-> (cpu_rdata == 8'hFF));
   // R4: pending read shows ones in bits 6:4 and irq in bit 7
   p_pend_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == A_PEND) |-> (cpu_rdata[6:4] == 3'b111 && cpu_rdata[7] == irq));
   // R3: raster read tracks the input
   p_raster_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == A_RASTER) |-> (cpu_rdata == raster_line[7:0]));
endmodule

// File: tb/vidreg_irq_unit_tb.sv
module vidreg_irq_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = '0;
   logic       cpu_we = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [8:0] raster_line = 9'h000;
   logic [7:0] pen_x = 8'h00;
   logic [7:0] pen_y = 8'h00;
   logic [3:0] src_pulse = '0;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vidreg_irq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .raster_line(raster_line),
      .pen_x(pen_x), .pen_y(pen_y), .src_pulse(src_pulse), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      cpu_addr = a;
      #1;
      chk(req, cpu_rdata, exp);
   endtask

   task automatic pulse(input logic [3:0] p);
      @(negedge clk);
      src_pulse = p;
      @(negedge clk);
      src_pulse = '0;
   endtask

   task automatic t_reset_state();
      rd_chk("R10 pending", 8'h19, 8'h70);
      rd_chk("R10 mask", 8'h1A, 8'hF0);
      rd_chk("R10 stored", 8'h05, 8'h00);
      chk("R10 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_live_reads();
      raster_line = 9'h1A5; pen_x = 8'h3C; pen_y = 8'hC3;
      wr(8'h11, 8'hFF);
      rd_chk("R2 ctrl1 line bit8 one", 8'h11, 8'hFF);
      raster_line = 9'h0A5;
      rd_chk("R2 ctrl1 line bit8 zero", 8'h11, 8'h7F);
      rd_chk("R3 raster low", 8'h12, 8'hA5);
      wr(8'h13, 8'h00);
      rd_chk("R3 pen x", 8'h13, 8'h3C);
      rd_chk("R3 pen y", 8'h14, 8'hC3);
   endtask

   task automatic t_plain_and_alias();
      wr(8'h05, 8'h5A);
      rd_chk("R5 plain", 8'h05, 8'h5A);
      rd_chk("R1 alias read", 8'hC5, 8'h5A);
      wr(8'h85, 8'h66);
      rd_chk("R1 alias write", 8'h05, 8'h66);
      wr(8'h25, 8'h03);
      rd_chk("R5 nibble", 8'h25, 8'hF3);
      wr(8'h30, 8'h00);
      rd_chk("R5 ones 30", 8'h30, 8'hFF);
      rd_chk("R5 ones 2F", 8'h2F, 8'hFF);
   endtask

   task automatic t_irq_flow();
      pulse(4'b0001);
      rd_chk("R8 raster flag", 8'h19, 8'h71);
      chk("R9 masked off", {7'd0, irq}, 8'h00);
      wr(8'h1A, 8'hF1);
      rd_chk("R7 mask low nibble", 8'h1A, 8'hF1);
      chk("R9 irq on", {7'd0, irq}, 8'h01);
      rd_chk("R4 summary bit", 8'h19, 8'hF1);
      wr(8'h19, 8'h81);
      rd_chk("R6 w1c", 8'h19, 8'h70);
      chk("R9 irq off", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_sources();
      wr(8'h1A, 8'h0F);
      pulse(4'b1000);
      rd_chk("R8 pen flag", 8'h19, 8'hF8);
      pulse(4'b0010);
      rd_chk("R8 sprbg flag", 8'h19, 8'hFA);
      @(negedge clk);
      cpu_addr = 8'h19; cpu_we = 1'b1; cpu_wdata = 8'h04; src_pulse = 4'b0100;
      @(negedge clk);
      cpu_we = 1'b0; src_pulse = '0;
      rd_chk("R6 pulse beats clear", 8'h19, 8'hFE);
      wr(8'h19, 8'h0A);
      rd_chk("R6 partial clear", 8'h19, 8'hF4);
      chk("R9 irq still on", {7'd0, irq}, 8'h01);
      wr(8'h1A, 8'h03);
      chk("R9 mask removes irq", {7'd0, irq}, 8'h00);
      rd_chk("R4 mask read", 8'h1A, 8'hF3);
      wr(8'h1A, 8'h04);
      chk("R9 mask restores irq", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_live_reads();
      t_plain_and_alias();
      t_irq_flow();
      t_sources();
      t_reset_again();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule